// File: doc/BRIEF.md
# Bit-Period Spread Spectrum Sequencer

This block lowers the radiated emissions of one serial channel. It gives each transmitted bit its own pseudo-random duration. Each bit lasts three cycles of the bit clock. At the end of every third bit-clock cycle the block picks a new step, which is one of 64 period offsets equally spaced in time. It then presents that step on two outputs: an unsigned step index, and a signed code for a modulation DAC that adds an offset to the oscillator period. The deviation select narrows the spread range by scaling the signed code down. The sequence select chooses which of four maximal-length pseudo-random sequences supplies the steps.

When spreading is off, the outputs sit at the centre step, so the period carries no offset. A change to the enable, the deviation or the sequence select takes effect only at the next bit boundary, so no bit is cut short. The step changes once per bit. This is much faster than any centre-frequency correction loop around the oscillator, so the two adjustments stay apart. One instance serves one channel.

Top module: `pss_top`

## Requirements
- R1: While reset is low at a clock edge, and after it until the first bit boundary, step_idx is 32 and dac_code is 0.
- R2: A bit boundary is the clock edge at which bclk_tick is high for the third time since reset or since the previous boundary. step_idx and dac_code change only one clock after a boundary strobe. They hold their values through every other tick and every clock cycle without a tick.
- R3: A 7-bit Galois right-shift register, seeded with 7'h5A at reset, advances once at every bit boundary, whether or not spreading is enabled. At each step the low bit is shifted out, and if it was 1 the shifted value is XORed with a mask. The mask is 7'h60 for seq_sel 0, 7'h48 for 1, 7'h44 for 2 and 7'h41 for 3.
- R4: When spread_en is 0 at a boundary, step_idx becomes 32 and dac_code becomes 0.
- R5: When spread_en is 1 at a boundary, step_idx becomes the low 6 bits of the advanced register. dac_code becomes (step_idx − 32), as a 6-bit two's complement value, arithmetically shifted right by dev_sel (0 to 3 bits).
- R6: Values of spread_en, dev_sel and seq_sel that are present only between boundaries have no effect. Only the values present at the boundary edge are used.
- R7: With seq_sel held fixed, the step sequence repeats after exactly 127 boundaries, and the register never holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spread_en | input | 1 | Spreading enable for this channel |
| dev_sel | input | 2 | Deviation: right shift applied to the signed code |
| seq_sel | input | 2 | Pseudo-random sequence (feedback mask) select |
| bclk_tick | input | 1 | One-clock strobe per bit-clock cycle |
| step_idx | output | 6 | Selected step, 0..63, centre 32 |
| dac_code | output | 6 | Signed, scaled offset code for the modulation DAC |

## Verification
A wrong tick count shows as outputs that move on the wrong tick, within the first bit after reset. A wrong feedback mask or seed gives a step_idx that departs from the bench's own register model at the first enabled boundary. A bad scale or sign shows on dac_code at that same boundary. Config leaking in between boundaries is caught on the tick where it happens, because the outputs are compared after every tick and after idle clocks.

// File: rtl/pss_pkg.sv
// Shared constants and helpers for the bit-period spread sequencer.
// Assumes a 7-bit register, for which every listed trinomial is primitive.
package pss_pkg;
    localparam int LFSR_W = 7;
    localparam int SEL_W  = 2;

    // Feedback mask for each sequence-select code (Galois right shift).
    function automatic logic [LFSR_W-1:0] fb_mask(input logic [SEL_W-1:0] sel);
        case (sel)
            2'd0:    fb_mask = 7'h60;
            2'd1:    fb_mask = 7'h48;
            2'd2:    fb_mask = 7'h44;
            default: fb_mask = 7'h41;
        endcase
    endfunction
endpackage

// File: rtl/pss_bit_timer.sv
// Counts bit-clock strobes and flags the one that closes each bit.
// Assumes bclk_tick is a single-cycle strobe; TICKS_PER_BIT >= 2.
module pss_bit_timer #(
    parameter int TICKS_PER_BIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_tick,
    output logic bit_edge
);
    localparam int CW = $clog2(TICKS_PER_BIT);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

    logic [CW-1:0] cnt_q;

    // Boundary is the last tick of the current bit.
    always_comb bit_edge = bclk_tick && (cnt_q == LAST);

    // Tick counter, wraps at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (bit_edge)   cnt_q <= '0;
        else if (bclk_tick)  cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pss_lfsr.sv
// Galois pseudo-random register with selectable feedback mask.
// Advances only on adv; nxt shows the value it takes at that edge.
module pss_lfsr
    import pss_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 7'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [SEL_W-1:0]  sel,
    output logic [LFSR_W-1:0] state,
    output logic [LFSR_W-1:0] nxt
);
    // One Galois step with the mask chosen by sel.
    always_comb begin
        nxt = state >> 1;
        if (state[0]) nxt = nxt ^ fb_mask(sel);
    end

    // State register, seeded nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= SEED;
        else if (adv) state <= nxt;
    end
endmodule

// File: rtl/pss_code_map.sv
// Turns a random step into the step index and a scaled signed DAC code.
// Loads only on load; holds the centre code while disabled.
module pss_code_map #(
    parameter int STEP_W = 6,
    parameter int DEV_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     en,
    input  logic [DEV_W-1:0]         dev,
    input  logic [STEP_W-1:0]        rnd,
    output logic [STEP_W-1:0]        idx,
    output logic signed [STEP_W-1:0] code
);
    localparam logic [STEP_W-1:0] CENTER = STEP_W'(1) << (STEP_W - 1);

    logic signed [STEP_W-1:0] off;
    logic signed [STEP_W-1:0] scaled;

    // Centre-relative offset, scaled down by the deviation code.
    always_comb begin
        off    = $signed(rnd ^ CENTER);
        scaled = off >>> dev;
    end

    // Output registers, updated once per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= CENTER;
            code <= '0;
        end else if (load) begin
            idx  <= en ? rnd : CENTER;
            code <= en ? scaled : '0;
        end
    end
endmodule

// File: rtl/pss_top.sv
// Bit-period spread sequencer for one channel: a new pseudo-random
// period step at each bit boundary (every TICKS_PER_BIT strobes).
// Config inputs are sampled only at the boundary edge.
module pss_top
    import pss_pkg::*;
#(
    parameter int TICKS_PER_BIT = 3,
    parameter int STEP_W        = 6,
    parameter logic [LFSR_W-1:0] SEED = 7'h5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spread_en,
    input  logic [1:0]        dev_sel,
    input  logic [1:0]        seq_sel,
    input  logic              bclk_tick,
    output logic [STEP_W-1:0] step_idx,
    output logic [STEP_W-1:0] dac_code
);
    logic                     bit_edge;
    logic [LFSR_W-1:0]        lfsr_q;
    logic [LFSR_W-1:0]        lfsr_d;
    logic signed [STEP_W-1:0] code_s;

    pss_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .bit_edge(bit_edge)
    );

    pss_lfsr #(.SEED(SEED)) u_lfsr (
        .clk(clk), .rst_n(rst_n), .adv(bit_edge), .sel(seq_sel),
        .state(lfsr_q), .nxt(lfsr_d)
    );

    pss_code_map #(.STEP_W(STEP_W), .DEV_W(2)) u_map (
        .clk(clk), .rst_n(rst_n), .load(bit_edge), .en(spread_en),
        .dev(dev_sel), .rnd(lfsr_d[STEP_W-1:0]), .idx(step_idx), .code(code_s)
    );

    // Present the signed code on a plain port.
    always_comb dac_code = code_s;
endmodule

// File: rtl/pss_checker.sv
// Checker for pss_top; bound to every instance below.
module pss_checker #(
    parameter int TICKS_PER_BIT = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       spread_en,
    input logic [1:0] dev_sel,
    input logic       bclk_tick,
    input logic       bit_edge,
    input logic [6:0] lfsr_q,
    input logic [5:0] step_idx,
    input logic [5:0] dac_code
);
    int unsigned ticks;

    // Own count of ticks since the last boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)          ticks <= 0;
        else if (bit_edge)   ticks <= 0;
        else if (bclk_tick)  ticks <= ticks + 1;
    end

    p_edge_third_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_edge |-> (bclk_tick && ticks == TICKS_PER_BIT - 1));

    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_edge |=> ($stable(step_idx) && $stable(dac_code)));

    p_center_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_edge && !spread_en) |=> (step_idx == 6'd32 && dac_code == 6'd0));

    p_scale_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_edge && spread_en) |=>
        ($signed(dac_code) == ($signed({~step_idx[5], step_idx[4:0]}) >>> $past(dev_sel))));

    p_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 7'd0);
endmodule

bind pss_top pss_checker #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .dev_sel(dev_sel),
    .bclk_tick(bclk_tick), .bit_edge(bit_edge), .lfsr_q(lfsr_q),
    .step_idx(step_idx), .dac_code(dac_code)
);

// File: tb/pss_top_test.sv
// Directed bench for pss_top, one task per scenario, with its own reference model.
module pss_top_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       spread_en = 0;
    logic [1:0] dev_sel = 0;
    logic [1:0] seq_sel = 0;
    logic       bclk_tick = 0;
    logic [5:0] step_idx;
    logic [5:0] dac_code;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state
    logic [6:0] m_reg;
    int         m_ticks;
    int         e_idx;
    int         e_dac;

    always #2 clk = ~clk;

    pss_top uut (
        .clk(clk), .rst_n(rst_n), .spread_en(spread_en), .dev_sel(dev_sel),
        .seq_sel(seq_sel), .bclk_tick(bclk_tick), .step_idx(step_idx), .dac_code(dac_code)
    );

    function automatic logic [6:0] m_step(input logic [6:0] s, input logic [1:0] q);
        logic [6:0] m;
        logic [6:0] r;
        m = (q == 0) ? 7'h60 : (q == 1) ? 7'h48 : (q == 2) ? 7'h44 : 7'h41;
        r = {1'b0, s[6:1]};
        return s[0] ? (r ^ m) : r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        check(int'(step_idx) == e_idx, {req, " step_idx"}, int'(step_idx), e_idx);
        check(int'($signed(dac_code)) == e_dac, {req, " dac_code"}, int'($signed(dac_code)), e_dac);
    endtask

    // One strobe; the model applies a boundary on every third.
    task automatic tick(input string req);
        int off;
        @(negedge clk) bclk_tick = 1;
        m_ticks++;
        if (m_ticks == 3) begin
            m_ticks = 0;
            m_reg = m_step(m_reg, seq_sel);
            if (spread_en) begin
                e_idx = int'(m_reg[5:0]);
                off = e_idx - 32;
                e_dac = off >>> dev_sel;
            end else begin
                e_idx = 32;
                e_dac = 0;
            end
        end
        @(negedge clk) bclk_tick = 0;
        check_out(req);
    endtask

    task automatic t_reset_r1();
        rst_n = 0;
        repeat (3) @(negedge clk);
        m_reg = 7'h5A; m_ticks = 0; e_idx = 32; e_dac = 0;
        check_out("R1 in reset");
        rst_n = 1;
        @(negedge clk);
        check_out("R1 after reset");
    endtask

    task automatic t_disabled_r4();
        spread_en = 0; dev_sel = 0; seq_sel = 0;
        for (int i = 0; i < 12; i++) tick("R4 disabled centre");
    endtask

    task automatic t_enabled_r3_r5();
        spread_en = 1;
        for (int d = 0; d < 4; d++) begin
            for (int q = 0; q < 4; q++) begin
                dev_sel = d[1:0]; seq_sel = q[1:0];
                for (int i = 0; i < 9; i++) tick("R3/R5 step and scale");
            end
        end
    endtask

    task automatic t_idle_r2();
        int hold_i;
        int hold_d;
        tick("R2 lead");
        hold_i = e_idx; hold_d = e_dac;
        repeat (5) @(negedge clk);
        check_out("R2 idle hold");
        tick("R2 second tick");
        repeat (4) @(negedge clk);
        check(int'(step_idx) == hold_i, "R2 hold until third", int'(step_idx), hold_i);
        check(int'($signed(dac_code)) == hold_d, "R2 hold dac", int'($signed(dac_code)), hold_d);
        tick("R2 third tick boundary");
    endtask

    task automatic t_midbit_r6();
        spread_en = 1; dev_sel = 0; seq_sel = 1;
        tick("R6 first tick");
        spread_en = 0; dev_sel = 3; seq_sel = 2;
        tick("R6 changed between boundaries");
        spread_en = 1; dev_sel = 1; seq_sel = 3;
        tick("R6 boundary uses present values");
        for (int i = 0; i < 6; i++) tick("R6 follow-on");
    endtask

    task automatic t_period_r7();
        int first;
        spread_en = 1; dev_sel = 0;
        for (int q = 0; q < 4; q++) begin
            seq_sel = q[1:0];
            while (m_ticks != 0) tick("R7 align");
            for (int k = 0; k < 3; k++) tick("R7 start");
            first = int'(step_idx);
            for (int b = 0; b < 127; b++)
                for (int k = 0; k < 3; k++) tick("R7 run");
            check(int'(step_idx) == first, "R7 period 127", int'(step_idx), first);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset_r1();
        t_disabled_r4();
        t_enabled_r3_r5();
        t_idle_r2();
        t_midbit_r6();
        t_period_r7();
        t_reset_r1();
        spread_en = 1;
        for (int i = 0; i < 6; i++) tick("R1/R3 reseed after reset");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule